// File: doc/BRIEF.md
# IO Translation Table Walker

This block turns a device DMA address into a system address. With each request it receives the address, a direction flag and a 64-bit translation descriptor. The descriptor holds a level count, a table-size code, a page-size code, a pass-through enable and the root table address. The block checks the descriptor and then takes one of two paths. In pass-through mode it forms a 4 KB page straight from the address. Otherwise it walks a tree of tables held in memory, one 8-byte read per level. It answers with a page-aligned system address, an offset mask and read/write permission bits, or with a fault code.

The walk logic uses a plain request/response memory port and keeps at most one read in flight. Table entries in memory are big-endian, and the block byte-reverses each one as it arrives. The block handles one walk at a time. It accepts a new request only after the previous one has been answered.

Top module: `iotw_walker`

## Requirements
- R1: Out of reset `req_ready` is 1 and `mem_req_valid` and `rsp_valid` are 0. `req_ready` is 1 only when no walk is in progress, and a request is taken when `req_valid` and `req_ready` are both 1.
- R2: The descriptor fields, with bits counted from the LSB, are: page-size code [4:0], pass-through enable bit 12, level count [15:13], table-size code [20:16] and root table address [63:24]. A level count above 4 answers with fault code 1 and makes no memory read.
- R3: A page-size code of 0 selects pass-through. With bit 12 set, the answer is page = address AND 0x0003_FFFF_FFFF_F000, mask = 0xFFF and permission = 2'b11, with no memory read. With bit 12 clear, the answer is fault code 2.
- R4: A nonzero page-size code together with a table-size code of 0 answers with fault code 3 and makes no memory read.
- R5: A translated walk issues level count + 1 reads. Index width W is the table-size code + 8, page shift P is the page-size code + 11, and the first base is the root address shifted left by 12. The shift starts at W × levels + P. Each read address is base OR (((address >> shift) AND (2^W − 1)) << 3), and the shift then drops by W.
- R6: A non-final entry whose bits [1:0] are both 0 ends the walk with fault code 4 and no further read. Otherwise the next base is that entry with bits [11:0] cleared.
- R7: The memory port returns each entry byte-reversed: `mem_rsp_data[63:56]` carries the least significant byte of the entry.
- R8: In the final entry, bit 1 grants write and bit 0 grants read. A write request without bit 1, or a read request without bit 0, answers with fault code 5.
- R9: A successful walk answers with page = final entry AND NOT (2^P − 1), mask = 2^P − 1 and permission = final entry bits [1:0]. The fault flag is 0 and the fault code is 0.
- R10: A read answered with `mem_rsp_err` set ends the walk with fault code 6 and no further read.
- R11: At most one memory read is outstanding. The read address stays stable while `mem_req_valid` waits for `mem_req_ready`.
- R12: `rsp_valid` is a one-cycle pulse. When it carries a fault, `rsp_fault` is 1 and page, mask and permission are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_addr | input | 64 | Device DMA address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_entry | input | 64 | Translation descriptor |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry as stored, big-endian |
| mem_rsp_err | input | 1 | Read failed |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 3 | Fault code, 0 when no fault |
| rsp_page | output | 64 | Translated page address |
| rsp_mask | output | 64 | Offset mask within the page |
| rsp_perm | output | 2 | Bit 1 write allowed, bit 0 read allowed |

## Verification
The assertions assume the memory side answers each accepted read exactly once and never sends a response before the read has been accepted. They also assume the descriptor and address are sampled only on the accepting edge. The bench memory model keeps to this. It accepts a read after a random stall, holds off for a random gap of zero to two cycles, and then returns one byte-reversed entry. The entry is a hash of the read address, with bits [1:0] either drawn from the address or forced, so that indirect faults, permission faults and clean walks all occur.

// File: rtl/iotw_pkg.sv
package iotw_pkg;
  // descriptor field layout (bit 0 = LSB)
  localparam int F_PSZ_LO      = 0;
  localparam int F_SZ_W        = 5;
  localparam int F_BYP         = 12;
  localparam int F_LVL_LO      = 13;
  localparam int F_LVL_W       = 3;
  localparam int F_TSZ_LO      = 16;
  localparam int F_TBL_LO      = 24;
  localparam int F_TBL_W       = 40;
  localparam int PG_SHIFT_BIAS = 11;
  localparam int IX_WIDTH_BIAS = 8;
  localparam int TBL_ALIGN     = 12;
  localparam int SH_W          = 8;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_LEVELS    = 3'd1,
    FLT_NO_BYPASS = 3'd2,
    FLT_NO_TABLE  = 3'd3,
    FLT_INDIRECT  = 3'd4,
    FLT_ACCESS    = 3'd5,
    FLT_BUS       = 3'd6
  } flt_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_ISSUE, ST_WAIT, ST_DONE
  } st_e;
endpackage

// File: rtl/iotw_tve_decode.sv
module iotw_tve_decode
  import iotw_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int MAX_LEVELS = 4
) (
  input  logic [ADDR_W-1:0]  entry,
  output logic [F_LVL_W-1:0] levels,
  output logic [SH_W-1:0]    pg_shift,
  output logic [SH_W-1:0]    ix_width,
  output logic [SH_W-1:0]    start_shift,
  output logic [ADDR_W-1:0]  root_base,
  output logic               bypass,
  output flt_e               fault
);
  logic [F_SZ_W-1:0] psz;
  logic [F_SZ_W-1:0] tsz;
  logic [SH_W-1:0]   span;
  logic [ADDR_W-1:0] unused_entry;

  assign unused_entry = entry;

  always_comb begin
    levels      = entry[F_LVL_LO +: F_LVL_W];
    psz         = entry[F_PSZ_LO +: F_SZ_W];
    tsz         = entry[F_TSZ_LO +: F_SZ_W];
    pg_shift    = SH_W'(psz) + SH_W'(PG_SHIFT_BIAS);
    ix_width    = SH_W'(tsz) + SH_W'(IX_WIDTH_BIAS);
    span        = SH_W'(ix_width * SH_W'(levels));
    start_shift = span + pg_shift;
    root_base   = '0;
    root_base[TBL_ALIGN +: F_TBL_W] = entry[F_TBL_LO +: F_TBL_W];
    bypass      = (psz == '0);
    if (int'(levels) > MAX_LEVELS)  fault = FLT_LEVELS;
    else if (bypass)                fault = entry[F_BYP] ? FLT_NONE : FLT_NO_BYPASS;
    else if (tsz == '0)             fault = FLT_NO_TABLE;
    else                            fault = FLT_NONE;
  end
endmodule

// File: rtl/iotw_index_gen.sv
module iotw_index_gen
  import iotw_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int ENTRY_LOG2 = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [SH_W-1:0]   shift,
  input  logic [SH_W-1:0]   ix_width,
  output logic [ADDR_W-1:0] ent_addr
);
  logic [ADDR_W-1:0] ix_mask;
  logic [ADDR_W-1:0] idx;

  always_comb begin
    ix_mask  = (ADDR_W'(1) << ix_width) - ADDR_W'(1);
    idx      = (vaddr >> shift) & ix_mask;
    ent_addr = base | (idx << ENTRY_LOG2);
  end
endmodule

// File: rtl/iotw_bswap.sv
module iotw_bswap #(
  parameter int BYTES = 8
) (
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign dout[8*i +: 8] = din[8*(BYTES-1-i) +: 8];
  end
endmodule

// File: rtl/iotw_walker.sv
module iotw_walker
  import iotw_pkg::*;
#(
  parameter int ADDR_W           = 64,
  parameter int MAX_LEVELS       = 4,
  parameter int BYPASS_ADDR_BITS = 50,
  parameter int BYPASS_PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_entry,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_page,
  output logic [ADDR_W-1:0] rsp_mask,
  output logic [1:0]        rsp_perm
);
  localparam int ENTRY_BYTES = ADDR_W / 8;
  localparam int ENTRY_LOG2  = $clog2(ENTRY_BYTES);
  localparam logic [ADDR_W-1:0] BYP_OFS_MASK  = (ADDR_W'(1) << BYPASS_PAGE_BITS) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] BYP_PAGE_MASK =
    ((ADDR_W'(1) << BYPASS_ADDR_BITS) - ADDR_W'(1)) & ~BYP_OFS_MASK;
  localparam logic [ADDR_W-1:0] TBL_LOW_MASK  = (ADDR_W'(1) << TBL_ALIGN) - ADDR_W'(1);

  st_e                st_q, st_d;
  logic [ADDR_W-1:0]  va_q, va_d;
  logic               wr_q, wr_d;
  logic [ADDR_W-1:0]  ent_q, ent_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [SH_W-1:0]    sh_q, sh_d;
  logic [F_LVL_W-1:0] left_q, left_d;
  flt_e               code_q, code_d;
  logic [ADDR_W-1:0]  page_q, page_d;
  logic [ADDR_W-1:0]  mask_q, mask_d;
  logic [1:0]         perm_q, perm_d;

  logic [F_LVL_W-1:0] dec_levels;
  logic [SH_W-1:0]    dec_pgs, dec_ixw, dec_start;
  logic [ADDR_W-1:0]  dec_root;
  logic               dec_bypass;
  flt_e               dec_fault;
  logic [ADDR_W-1:0]  fetched;
  logic [ADDR_W-1:0]  pg_mask;
  logic               perm_bad;

  iotw_tve_decode #(.ADDR_W(ADDR_W), .MAX_LEVELS(MAX_LEVELS)) u_decode (
    .entry(ent_q), .levels(dec_levels), .pg_shift(dec_pgs), .ix_width(dec_ixw),
    .start_shift(dec_start), .root_base(dec_root), .bypass(dec_bypass), .fault(dec_fault)
  );

  iotw_index_gen #(.ADDR_W(ADDR_W), .ENTRY_LOG2(ENTRY_LOG2)) u_index (
    .base(base_q), .vaddr(va_q), .shift(sh_q), .ix_width(dec_ixw), .ent_addr(mem_req_addr)
  );

  iotw_bswap #(.BYTES(ENTRY_BYTES)) u_swap (.din(mem_rsp_data), .dout(fetched));

  assign pg_mask  = (ADDR_W'(1) << dec_pgs) - ADDR_W'(1);
  assign perm_bad = wr_q ? !fetched[1] : !fetched[0];

  // next state
  always_comb begin
    st_d = st_q;   va_d = va_q;   wr_d = wr_q;   ent_d = ent_q;
    base_d = base_q; sh_d = sh_q; left_d = left_q;
    code_d = code_q; page_d = page_q; mask_d = mask_q; perm_d = perm_q;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d = ST_CHECK; va_d = req_addr; wr_d = req_write; ent_d = req_entry;
        code_d = FLT_NONE; page_d = '0; mask_d = '0; perm_d = '0;
      end
      ST_CHECK: begin
        if (dec_fault != FLT_NONE) begin
          code_d = dec_fault; st_d = ST_DONE;
        end else if (dec_bypass) begin
          page_d = va_q & BYP_PAGE_MASK; mask_d = BYP_OFS_MASK; perm_d = 2'b11;
          st_d = ST_DONE;
        end else begin
          base_d = dec_root; sh_d = dec_start; left_d = dec_levels; st_d = ST_ISSUE;
        end
      end
      ST_ISSUE: if (mem_req_ready) st_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          code_d = FLT_BUS; st_d = ST_DONE;
        end else if (left_q != '0) begin
          if (fetched[1:0] == 2'b00) begin
            code_d = FLT_INDIRECT; st_d = ST_DONE;
          end else begin
            base_d = fetched & ~TBL_LOW_MASK;
            sh_d   = sh_q - dec_ixw;
            left_d = left_q - F_LVL_W'(1);
            st_d   = ST_ISSUE;
          end
        end else if (perm_bad) begin
          code_d = FLT_ACCESS; st_d = ST_DONE;
        end else begin
          page_d = fetched & ~pg_mask; mask_d = pg_mask; perm_d = fetched[1:0];
          st_d = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; va_q <= '0; wr_q <= 1'b0; ent_q <= '0;
      base_q <= '0; sh_q <= '0; left_q <= '0;
      code_q <= FLT_NONE; page_q <= '0; mask_q <= '0; perm_q <= '0;
    end else begin
      st_q <= st_d; va_q <= va_d; wr_q <= wr_d; ent_q <= ent_d;
      base_q <= base_d; sh_q <= sh_d; left_q <= left_d;
      code_q <= code_d; page_q <= page_d; mask_q <= mask_d; perm_q <= perm_d;
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_ISSUE);
  assign rsp_valid     = (st_q == ST_DONE);
  assign rsp_fault     = (code_q != FLT_NONE);
  assign rsp_code      = code_q;
  assign rsp_page      = page_q;
  assign rsp_mask      = mask_q;
  assign rsp_perm      = perm_q;

  // assertions
  a_r1_busy_while_answering: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
  a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r5_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[ENTRY_LOG2-1:0] == '0));
  a_r9_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (((rsp_mask + ADDR_W'(1)) & rsp_mask) == '0));
  a_r9_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> ((rsp_page & rsp_mask) == '0));
  a_r8_write_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault && wr_q) |-> rsp_perm[1]);
  a_r12_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_page == '0 && rsp_mask == '0 && rsp_perm == 2'b00));
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/iotw_walker_test.sv
module iotw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [63:0] req_addr, req_entry;
  logic        mem_req_valid, mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_code;
  logic [63:0] rsp_page, rsp_mask;
  logic [1:0]  rsp_perm;

  always #4 clk = ~clk;  // 125 MHz

  iotw_walker uut (.*);

  int n_checks = 0;
  int n_errors = 0;
  int err_after = -1;
  int pmode = 0;
  int nreads = 0;
  int ovl_err = 0;
  logic [63:0] cap_addr;
  logic [63:0] addr_log [8];
  logic [63:0] exp_addr [8];
  int          exp_n;
  logic [2:0]  exp_code;
  logic [63:0] exp_page, exp_mask;
  logic [1:0]  exp_perm;

  function automatic logic [63:0] bswap64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] mem_fn(input logic [63:0] a);
    logic [63:0] h;
    logic [1:0]  pb;
    h = a * 64'h9E37_79B9_7F4A_7C15;
    h = h ^ (h >> 29);
    case (pmode)
      0:       pb = a[4:3];
      1:       pb = 2'b11;
      2:       pb = 2'b00;
      default: pb = 2'b01;
    endcase
    return (h & 64'h000F_FFFF_FFFF_F000) | {62'b0, pb};
  endfunction

  function automatic logic [63:0] mk(input logic [39:0] tbl, input int lev, input int tsz,
                                     input int psz, input bit byp);
    return {tbl, 3'b0, 5'(tsz), 3'(lev), byp, 7'b0, 5'(psz)};
  endfunction

  function automatic string code_tag(input logic [2:0] c);
    case (c)
      3'd1: return "R2";  3'd2: return "R3";  3'd3: return "R4";
      3'd4: return "R6";  3'd5: return "R8";  3'd6: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] va, input logic wr, input logic [63:0] e);
    int lev, ts, ps, sh;
    logic [63:0] base, v, ea;
    exp_n = 0; exp_code = 0; exp_page = 0; exp_mask = 0; exp_perm = 0;
    lev = int'(e[15:13]); ps = int'(e[4:0]); ts = int'(e[20:16]);
    if (lev > 4) exp_code = 1;
    else if (ps == 0) begin
      if (!e[12]) exp_code = 2;
      else begin
        exp_page = va & 64'h0003_FFFF_FFFF_F000; exp_mask = 64'hFFF; exp_perm = 2'b11;
      end
    end else if (ts == 0) exp_code = 3;
    else begin
      ps = ps + 11; ts = ts + 8;
      base = {12'b0, e[63:24], 12'b0};
      sh = ts * lev + ps;
      for (int i = 0; i <= lev; i++) begin
        ea = base | (((va >> sh) & ((64'd1 << ts) - 64'd1)) << 3);
        exp_addr[i] = ea; exp_n++;
        if (err_after == i) begin exp_code = 6; break; end
        v = mem_fn(ea);
        if (i < lev) begin
          if (v[1:0] == 2'b00) begin exp_code = 4; break; end
          base = v & ~64'hFFF; sh = sh - ts;
        end else if (wr ? !v[1] : !v[0]) exp_code = 5;
        else begin
          exp_mask = (64'd1 << ps) - 64'd1; exp_page = v & ~exp_mask; exp_perm = v[1:0];
        end
      end
    end
  endtask

  task automatic run(input logic [63:0] va, input logic wr, input logic [63:0] e);
    int waitc;
    string t;
    model(va, wr, e);
    t = code_tag(exp_code);
    if (exp_code == 0 && e[4:0] == 5'd0) t = "R3";
    nreads = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = va; req_write = wr; req_entry = e;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1 busy after accept", 64'(req_ready), 64'd0);
    waitc = 0;
    while (!rsp_valid && waitc < 500) begin @(negedge clk); waitc++; end
    check(rsp_valid == 1'b1, "R12 answer arrives", 64'(rsp_valid), 64'd1);
    check(rsp_code == exp_code, {t, " fault code"}, 64'(rsp_code), 64'(exp_code));
    check(rsp_fault == (exp_code != 0), {t, " fault flag"}, 64'(rsp_fault), 64'(exp_code != 0));
    if (exp_code != 0) t = "R12";
    check(rsp_page == exp_page, {t, " page"}, rsp_page, exp_page);
    check(rsp_mask == exp_mask, {t, " mask"}, rsp_mask, exp_mask);
    check(rsp_perm == exp_perm, {t, " perm"}, 64'(rsp_perm), 64'(exp_perm));
    check(nreads == exp_n, "R5 read count", 64'(nreads), 64'(exp_n));
    for (int i = 0; i < exp_n && i < nreads && i < 8; i++)
      check(addr_log[i] == exp_addr[i], "R5 read address", addr_log[i], exp_addr[i]);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R12 single pulse", 64'(rsp_valid), 64'd0);
  endtask

  // memory responder: entries stored big-endian (R7)
  initial begin : responder
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
      if (mem_req_valid && ($urandom % 4 != 0)) begin
        mem_req_ready = 1'b1; cap_addr = mem_req_addr;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (mem_req_valid) ovl_err++;
        if (nreads < 8) addr_log[nreads] = cap_addr;
        repeat ($urandom % 3) begin
          @(negedge clk);
          if (mem_req_valid) ovl_err++;
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_err   = (nreads == err_after);
        mem_rsp_data  = bswap64(mem_fn(cap_addr));
        nreads++;
      end else mem_req_ready = 1'b0;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    logic [63:0] va, e;
    void'($urandom(32'h1D5EED));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_entry = '0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    check(mem_req_valid == 1'b0, "R1 reset no read", 64'(mem_req_valid), 64'd0);
    check(rsp_valid == 1'b0, "R1 reset no answer", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    pmode = 1;
    run(64'h0000_0012_3456_7000, 1'b0, mk(40'h12345, 5, 1, 1, 1'b0));  // R2
    run(64'h0000_0012_3456_7000, 1'b0, mk(40'h12345, 7, 2, 3, 1'b1));  // R2
    run(64'hFFFF_1234_5678_9ABC, 1'b1, mk(40'h0, 0, 0, 0, 1'b1));      // R3
    run(64'hFFFF_1234_5678_9ABC, 1'b0, mk(40'h0, 2, 1, 0, 1'b0));      // R3 off
    run(64'h0000_0000_8000_0000, 1'b0, mk(40'hABCDE, 1, 0, 1, 1'b0));  // R4
    run(64'h0123_4567_89AB_CDEF, 1'b1, mk(40'h00F0F0, 4, 1, 1, 1'b0)); // R5 deep
    run(64'h0000_7654_3210_F000, 1'b0, mk(40'h0A0A0, 2, 3, 9, 1'b0));  // R9 large page
    pmode = 2;
    run(64'h0000_00FF_FFFF_F000, 1'b0, mk(40'h55555, 2, 1, 1, 1'b0));  // R6
    run(64'h0000_00FF_FFFF_F000, 1'b0, mk(40'h55555, 0, 1, 1, 1'b0));  // R8 no rights
    pmode = 3;
    run(64'h0000_0001_2345_6000, 1'b1, mk(40'h31337, 0, 2, 1, 1'b0));  // R8 write denied
    run(64'h0000_0001_2345_6000, 1'b0, mk(40'h31337, 1, 2, 1, 1'b0));  // R8 read allowed
    pmode = 1; err_after = 2;
    run(64'h0000_0ABC_DEF0_1000, 1'b0, mk(40'h77777, 3, 1, 2, 1'b0));  // R10
    err_after = 0;
    run(64'h0000_0ABC_DEF0_1000, 1'b1, mk(40'h77777, 0, 1, 2, 1'b0));  // R10 first read
    err_after = -1;

    pmode = 0;
    for (int k = 0; k < 200; k++) begin
      va = {$urandom, $urandom};
      e  = mk(40'({$urandom, $urandom}),
              ($urandom % 10 == 0) ? 5 + int'($urandom % 3) : int'($urandom % 5),
              ($urandom % 8 == 0) ? 0 : 1 + int'($urandom % 3),
              int'($urandom % 5), 1'($urandom));
      err_after = ($urandom % 12 == 0) ? int'($urandom % 3) : -1;
      run(va, 1'($urandom), e);
    end
    err_after = -1;

    check(ovl_err == 0, "R11 one read outstanding", 64'(ovl_err), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule